// File: doc/BRIEF.md
# Display Self-Test Timing and Pattern Generator

This block produces horizontal and vertical blanking-style timing pulses from its own clock, together with a one-bit video level carrying a test picture. With it, a monitor can be burned in or checked without any external video source. A 2-bit select sets the line period to one of four fixed lengths: 126, 189, 252 or 378 clocks. At 12 MHz these lengths give line rates of about 95.2, 63.5, 47.6 and 31.75 kHz. A 1-bit select picks a 72 Hz or 60 Hz frame rate. The number of lines in a frame follows from the clock rate, the line period and the frame rate.

Each of the two blanking outputs passes through its own output selector, set by software. The selector chooses the raw sync input, the composite-derived sync input or the internal self-test timing, and it can invert the result. The picture is one of four: a grid of bright lines, the same grid inverted, solid bright or solid dark. Changes to the pattern select and the rate selects are held back until the current frame ends. As a result, every frame produced is complete and uses one setting throughout.

Top module: `selftest_pattern_gen`

## Requirements
- R1: Pattern select encoding: 0 = grid, 1 = inverted grid, 2 = solid high, 3 = solid low. In grid mode `pat_o` is 1 when the pixel position in the line is a multiple of 16, or when the line number in the frame is a multiple of 16. Otherwise it is 0.
- R2: Line-rate select values 0, 1, 2 and 3 give line periods of 126, 189, 252 and 378 clocks (default parameters).
- R3: Frame-rate select 0 means 72 Hz and 1 means 60 Hz. Lines per frame equal CLK_HZ divided by (line period × frame rate), rounded down.
- R4: The self-test horizontal pulse is active-high and lasts round(0.08 × line period) clocks, starting at pixel 0 of each line.
- R5: The self-test vertical pulse is active-high and lasts round(0.08 × lines per frame) lines, starting at line 0 of each frame.
- R6: A change to the pattern or rate selects takes effect only at the next frame start. A frame already under way keeps its setting to the end.
- R7: Each output selector decodes select 0 as the raw sync input, 1 as the composite-derived input, and 2 or 3 as the self-test timing. The horizontal and vertical selectors are independent.
- R8: A set polarity bit inverts its own blanking output after the selector.
- R9: While `enable_i` is low, the self-test pulses and `pat_o` are 0 and the counters are held at the frame start. The first clock edge with `enable_i` high begins a new frame at line 0, pixel 0.
- R10: All outputs are registered. A pass-through input appears on its output one clock edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (12 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Runs the self-test timing |
| pat_sel_i | input | 2 | Picture select |
| hrate_sel_i | input | 2 | Line-period select |
| vrate_sel_i | input | 1 | Frame-rate select |
| hsync_in | input | 1 | Raw horizontal sync |
| hcomp_in | input | 1 | Composite-derived horizontal pulse |
| vsync_in | input | 1 | Raw vertical sync |
| vcomp_in | input | 1 | Composite-derived vertical sync |
| hmux_sel_i | input | 2 | Horizontal output source |
| vmux_sel_i | input | 2 | Vertical output source |
| hpol_inv_i | input | 1 | Invert horizontal output |
| vpol_inv_i | input | 1 | Invert vertical output |
| hblank_o | output | 1 | Horizontal blanking output |
| vblank_o | output | 1 | Vertical blanking output |
| pat_o | output | 1 | Test picture level |

## Verification
Pass-through inputs are driven at a falling edge and compared at the next falling edge, which is one register stage later. The self-test outputs and `pat_o` share that single stage, so they stay aligned with each other. Because of this alignment, the bench takes the frame origin from the sample where the vertical output rises and counts pixel and line positions from that point. The bench then measures each period, pulse width and grid position in its own counters. Select changes are applied in the sample right after a frame start and are expected to appear only at the following frame start. When enable is raised, both pulses are expected to be high at the very next sample.

// File: rtl/stp_pkg.sv
package stp_pkg;

  typedef enum logic [1:0] {
    PAT_GRID     = 2'd0,
    PAT_GRID_INV = 2'd1,
    PAT_SOLID_HI = 2'd2,
    PAT_SOLID_LO = 2'd3
  } stp_pat_e;

  typedef struct packed {
    stp_pat_e   pat;
    logic [1:0] hsel;
    logic       vsel;
  } stp_cfg_t;

  function automatic int unsigned lines_per_frame(int unsigned clk_hz, int unsigned per,
                                                  int unsigned rate);
    return clk_hz / (per * rate);
  endfunction

  function automatic int unsigned pct8(int unsigned n);
    return (n * 8 + 50) / 100;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned min2(int unsigned a, int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/stp_timing.sv
module stp_timing
  import stp_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 12000000,
  parameter int unsigned H_PER0  = 126,
  parameter int unsigned H_PER1  = 189,
  parameter int unsigned H_PER2  = 252,
  parameter int unsigned H_PER3  = 378,
  parameter int unsigned V_RATE0 = 72,
  parameter int unsigned V_RATE1 = 60,
  parameter int unsigned HCW     = 9,
  parameter int unsigned VCW     = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  stp_cfg_t       cfg_in,
  output stp_cfg_t       cfg_q,
  output logic [HCW-1:0] hcnt,
  output logic [VCW-1:0] vcnt,
  output logic           st_h,
  output logic           st_v
);
  localparam int unsigned HPER  [4] = '{H_PER0, H_PER1, H_PER2, H_PER3};
  localparam int unsigned VRATE [2] = '{V_RATE0, V_RATE1};

  logic [HCW-1:0] hl_tab [4];
  logic [HCW-1:0] hw_tab [4];
  logic [VCW-1:0] vl_tab [8];
  logic [VCW-1:0] vw_tab [8];

  for (genvar i = 0; i < 4; i++) begin : g_hline
    assign hl_tab[i] = HCW'(HPER[i] - 1);
    assign hw_tab[i] = HCW'(pct8(HPER[i]));
  end

  for (genvar j = 0; j < 8; j++) begin : g_frame
    localparam int unsigned NL = lines_per_frame(CLK_HZ, HPER[j/2], VRATE[j%2]);
    assign vl_tab[j] = VCW'(NL - 1);
    assign vw_tab[j] = VCW'(pct8(NL));
  end

  logic [HCW-1:0] hlast, hwid;
  logic [VCW-1:0] vlast, vwid;
  logic           line_end, frame_end, load;

  always_comb begin
    hlast     = hl_tab[cfg_q.hsel];
    hwid      = hw_tab[cfg_q.hsel];
    vlast     = vl_tab[{cfg_q.hsel, cfg_q.vsel}];
    vwid      = vw_tab[{cfg_q.hsel, cfg_q.vsel}];
    line_end  = (hcnt == hlast);
    frame_end = line_end && (vcnt == vlast);
    load      = !en || frame_end;
    st_h      = en && (hcnt < hwid);
    st_v      = en && (vcnt < vwid);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      hcnt  <= '0;
      vcnt  <= '0;
    end else begin
      if (load) cfg_q <= cfg_in;
      if (!en) begin
        hcnt <= '0;
        vcnt <= '0;
      end else if (line_end) begin
        hcnt <= '0;
        vcnt <= frame_end ? '0 : vcnt + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  a_r2_hcnt_bound: assert property (@(posedge clk) disable iff (rst) hcnt <= hlast);
  a_r3_vcnt_bound: assert property (@(posedge clk) disable iff (rst) vcnt <= vlast);
  a_r6_cfg_at_origin: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q) |-> (hcnt == '0 && vcnt == '0));
  a_r9_idle_origin: assert property (@(posedge clk) disable iff (rst)
    !en |=> (hcnt == '0 && vcnt == '0));

endmodule

// File: rtl/stp_pattern.sv
module stp_pattern
  import stp_pkg::*;
#(
  parameter int unsigned HCW  = 9,
  parameter int unsigned VCW  = 11,
  parameter int unsigned GRID = 16
) (
  input  logic           en,
  input  stp_pat_e       sel,
  input  logic [HCW-1:0] hcnt,
  input  logic [VCW-1:0] vcnt,
  output logic           pat
);
  logic on_grid;

  always_comb begin
    on_grid = ((32'(hcnt) % GRID) == 0) || ((32'(vcnt) % GRID) == 0);
    unique case (sel)
      PAT_GRID:     pat = on_grid;
      PAT_GRID_INV: pat = !on_grid;
      PAT_SOLID_HI: pat = 1'b1;
      default:      pat = 1'b0;
    endcase
    if (!en) pat = 1'b0;
  end

endmodule

// File: rtl/stp_outmux.sv
module stp_outmux (
  input  logic       clk,
  input  logic       rst,
  input  logic       raw_i,
  input  logic       comp_i,
  input  logic       st_i,
  input  logic [1:0] sel_i,
  input  logic       inv_i,
  output logic       q_o
);
  logic pick;

  always_comb begin
    case (sel_i)
      2'd0:    pick = raw_i;
      2'd1:    pick = comp_i;
      default: pick = st_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q_o <= 1'b0;
    else     q_o <= pick ^ inv_i;
  end

  a_r8_polarity: assert property (@(posedge clk) disable iff (rst)
    (sel_i == 2'd1 && inv_i) |=> (q_o == !$past(comp_i)));

endmodule

// File: rtl/selftest_pattern_gen.sv
module selftest_pattern_gen
  import stp_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 12000000,
  parameter int unsigned H_PER0  = 126,
  parameter int unsigned H_PER1  = 189,
  parameter int unsigned H_PER2  = 252,
  parameter int unsigned H_PER3  = 378,
  parameter int unsigned V_RATE0 = 72,
  parameter int unsigned V_RATE1 = 60,
  parameter int unsigned GRID    = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable_i,
  input  logic [1:0] pat_sel_i,
  input  logic [1:0] hrate_sel_i,
  input  logic       vrate_sel_i,
  input  logic       hsync_in,
  input  logic       hcomp_in,
  input  logic       vsync_in,
  input  logic       vcomp_in,
  input  logic [1:0] hmux_sel_i,
  input  logic [1:0] vmux_sel_i,
  input  logic       hpol_inv_i,
  input  logic       vpol_inv_i,
  output logic       hblank_o,
  output logic       vblank_o,
  output logic       pat_o
);
  localparam int unsigned HMAX  = max2(max2(H_PER0, H_PER1), max2(H_PER2, H_PER3));
  localparam int unsigned HMIN  = min2(min2(H_PER0, H_PER1), min2(H_PER2, H_PER3));
  localparam int unsigned NLMAX = max2(lines_per_frame(CLK_HZ, HMIN, V_RATE0),
                                       lines_per_frame(CLK_HZ, HMIN, V_RATE1));
  localparam int unsigned HCW   = $clog2(HMAX);
  localparam int unsigned VCW   = $clog2(NLMAX);

  stp_cfg_t       cfg_in, cfg_q;
  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;
  logic           st_h, st_v, pat_d;

  assign cfg_in = '{pat: stp_pat_e'(pat_sel_i), hsel: hrate_sel_i, vsel: vrate_sel_i};

  stp_timing #(
    .CLK_HZ(CLK_HZ), .H_PER0(H_PER0), .H_PER1(H_PER1), .H_PER2(H_PER2), .H_PER3(H_PER3),
    .V_RATE0(V_RATE0), .V_RATE1(V_RATE1), .HCW(HCW), .VCW(VCW)
  ) u_timing (
    .clk(clk), .rst(rst), .en(enable_i), .cfg_in(cfg_in), .cfg_q(cfg_q),
    .hcnt(hcnt), .vcnt(vcnt), .st_h(st_h), .st_v(st_v)
  );

  stp_pattern #(.HCW(HCW), .VCW(VCW), .GRID(GRID)) u_pattern (
    .en(enable_i), .sel(cfg_q.pat), .hcnt(hcnt), .vcnt(vcnt), .pat(pat_d)
  );

  logic [1:0] m_raw, m_comp, m_st, m_inv, m_q;
  logic [1:0] m_sel [2];

  assign m_raw    = {vsync_in, hsync_in};
  assign m_comp   = {vcomp_in, hcomp_in};
  assign m_st     = {st_v, st_h};
  assign m_inv    = {vpol_inv_i, hpol_inv_i};
  assign m_sel[0] = hmux_sel_i;
  assign m_sel[1] = vmux_sel_i;

  for (genvar c = 0; c < 2; c++) begin : g_out
    stp_outmux u_mux (
      .clk(clk), .rst(rst), .raw_i(m_raw[c]), .comp_i(m_comp[c]), .st_i(m_st[c]),
      .sel_i(m_sel[c]), .inv_i(m_inv[c]), .q_o(m_q[c])
    );
  end

  assign hblank_o = m_q[0];
  assign vblank_o = m_q[1];

  always_ff @(posedge clk) begin
    if (rst) pat_o <= 1'b0;
    else     pat_o <= pat_d;
  end

  a_r7_raw_pass: assert property (@(posedge clk) disable iff (rst)
    (hmux_sel_i == 2'd0 && !hpol_inv_i) |=> (hblank_o == $past(hsync_in)));
  a_r8_idle_inverted: assert property (@(posedge clk) disable iff (rst)
    (!enable_i && vmux_sel_i[1] && vpol_inv_i) |=> vblank_o);
  a_r9_pat_quiet: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> !pat_o);
  a_r10_timing_reg: assert property (@(posedge clk) disable iff (rst)
    (hmux_sel_i == 2'd2 && !hpol_inv_i) |=> (hblank_o == $past(st_h)));

endmodule

// File: tb/test_selftest_pattern_gen.sv
module test_selftest_pattern_gen;
  localparam int unsigned CLK_HZ = 240000;

  logic clk = 0, rst = 1, enable_i = 0, vrate_sel_i = 0;
  logic [1:0] pat_sel_i = 0, hrate_sel_i = 0, hmux_sel_i = 2, vmux_sel_i = 2;
  logic hsync_in = 0, hcomp_in = 0, vsync_in = 0, vcomp_in = 0;
  logic hpol_inv_i = 0, vpol_inv_i = 0;
  logic hblank_o, vblank_o, pat_o;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  selftest_pattern_gen #(.CLK_HZ(CLK_HZ)) i_selftest_pattern_gen (
    .clk(clk), .rst(rst), .enable_i(enable_i), .pat_sel_i(pat_sel_i),
    .hrate_sel_i(hrate_sel_i), .vrate_sel_i(vrate_sel_i), .hsync_in(hsync_in),
    .hcomp_in(hcomp_in), .vsync_in(vsync_in), .vcomp_in(vcomp_in),
    .hmux_sel_i(hmux_sel_i), .vmux_sel_i(vmux_sel_i), .hpol_inv_i(hpol_inv_i),
    .vpol_inv_i(vpol_inv_i), .hblank_o(hblank_o), .vblank_o(vblank_o), .pat_o(pat_o)
  );

  // pat, hsel, vsel, line period, h width, lines, v width (lines)
  localparam int VEC [8][7] = '{
    '{0, 0, 0, 126, 10, 26, 2},
    '{1, 1, 1, 189, 15, 21, 2},
    '{2, 2, 0, 252, 20, 13, 1},
    '{3, 3, 1, 378, 30, 10, 1},
    '{0, 3, 0, 378, 30,  8, 1},
    '{1, 0, 1, 126, 10, 31, 2},
    '{0, 2, 1, 252, 20, 15, 1},
    '{1, 1, 0, 189, 15, 17, 1}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_pat(int p, int pos, int line);
    logic g = (pos % 16 == 0) || (line % 16 == 0);
    case (p)
      0: return g;
      1: return !g;
      2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wait_vrise();
    logic vp = vblank_o;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (vblank_o && !vp) return;
      vp = vblank_o;
    end
    check("R3 frame start seen", 0, 1);
  endtask

  // Starts on the sample where vblank_o rose; ends on the next such sample.
  task automatic frame_scan(input int p, input int per, output int per_bad, output int hw,
                            output int nl, output int vw, output int pbad);
    int pos = 0, line = 0;
    logic hp, vp;
    bit done = 0;
    per_bad = 0; hw = 0; nl = 0; vw = 0; pbad = 0;
    for (int k = 0; k < 20000 && !done; k++) begin
      if (pos == 0 && vblank_o) vw++;
      if (line == 0 && hblank_o) hw++;
      if (pat_o !== exp_pat(p, pos, line)) pbad++;
      hp = hblank_o; vp = vblank_o;
      @(negedge clk);
      pos++;
      if (vblank_o && !vp) begin
        done = 1; nl = line + 1;
        if (pos != per) per_bad++;
      end else if (hblank_o && !hp) begin
        if (pos != per) per_bad++;
        pos = 0; line++;
      end
    end
    if (!done) per_bad++;
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pb, hw, nl, vw, pt;
    repeat (4) @(negedge clk);
    check("R10 reset hblank", hblank_o, 0);
    check("R10 reset vblank", vblank_o, 0);
    check("R10 reset pat", pat_o, 0);
    rst = 0;

    // R9: idle while disabled
    pat_sel_i = 2;
    repeat (20) @(negedge clk);
    check("R9 idle hblank", hblank_o, 0);
    check("R9 idle vblank", vblank_o, 0);
    check("R9 idle pat", pat_o, 0);
    enable_i = 1;
    @(negedge clk);
    check("R9 start hblank", hblank_o, 1);
    check("R9 start vblank", vblank_o, 1);
    check("R9 start pat", pat_o, 1);

    // R1..R5 table walk
    for (int v = 0; v < 8; v++) begin
      pat_sel_i = 2'(VEC[v][0]); hrate_sel_i = 2'(VEC[v][1]); vrate_sel_i = VEC[v][2][0];
      wait_vrise();
      frame_scan(VEC[v][0], VEC[v][3], pb, hw, nl, vw, pt);
      check($sformatf("R2 line period vec%0d", v), pb, 0);
      check($sformatf("R4 h width vec%0d", v), hw, VEC[v][4]);
      check($sformatf("R3 lines vec%0d", v), nl, VEC[v][5]);
      check($sformatf("R5 v width vec%0d", v), vw, VEC[v][6]);
      check($sformatf("R1 pattern vec%0d", v), pt, 0);
    end

    // R6: change right after a frame start
    pat_sel_i = 0; hrate_sel_i = 0; vrate_sel_i = 0;
    wait_vrise();
    wait_vrise();
    pat_sel_i = 2; hrate_sel_i = 3;
    frame_scan(0, 126, pb, hw, nl, vw, pt);
    check("R6 old period kept", pb, 0);
    check("R6 old lines kept", nl, 26);
    check("R6 old pattern kept", pt, 0);
    frame_scan(2, 378, pb, hw, nl, vw, pt);
    check("R6 new period", pb, 0);
    check("R6 new lines", nl, 8);
    check("R6 new pattern", pt, 0);

    // R7/R10: pass-through sources, one edge later
    hmux_sel_i = 0; vmux_sel_i = 1;
    begin
      int e = 0;
      for (int i = 0; i < 16; i++) begin
        hsync_in = i[0] ^ i[2]; vcomp_in = i[1];
        hcomp_in = ~i[0]; vsync_in = i[3];
        @(negedge clk);
        if (hblank_o != (i[0] ^ i[2]) || vblank_o != i[1]) e++;
      end
      check("R7 R10 raw h / composite v", e, 0);
    end
    // R7/R8: swapped sources with inversion
    hmux_sel_i = 1; vmux_sel_i = 0; hpol_inv_i = 1; vpol_inv_i = 1;
    begin
      int e = 0;
      for (int i = 0; i < 16; i++) begin
        hcomp_in = i[1] ^ i[3]; vsync_in = i[0];
        hsync_in = i[2]; vcomp_in = ~i[0];
        @(negedge clk);
        if (hblank_o != !(i[1] ^ i[3]) || vblank_o != !i[0]) e++;
      end
      check("R7 R8 composite h / raw v inverted", e, 0);
    end
    // R8: inverted idle self-test timing
    enable_i = 0; hmux_sel_i = 2; vmux_sel_i = 3;
    repeat (3) @(negedge clk);
    check("R8 inverted idle hblank", hblank_o, 1);
    check("R8 inverted idle vblank", vblank_o, 1);
    hpol_inv_i = 0;
    @(negedge clk);
    check("R8 polarity per output h", hblank_o, 0);
    check("R8 polarity per output v", vblank_o, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule